// File: doc/BRIEF.md
# Handshaked Serial Byte Transmitter

This block turns one parallel byte at a time into an asynchronous serial frame on a single line. A host first places a byte on the data bus and raises the write-qualifier input. While the controller rests in its idle state, the next baud tick copies the held byte into a ten-bit frame register, and the controller then moves to a waiting state. In that state it does nothing until the host raises a start request on a baud tick.

Once started, the block sends the frame least significant bit first, one bit per baud tick. Each shift fills a one into the top of the frame register. When all ten bits are out, the block raises a single-cycle end-of-frame strobe, drops busy and returns to idle. There it picks up whatever the data register holds at that time.

The baud tick is a single-cycle enable that a divider outside this block produces. Every state change and every shift happens only on cycles where that tick is high.

Top module: `sertx_top`

## Requirements
- R1: While the active-low reset `rstN` is low, and straight after its release, `serOut` is 1, `busy` is 0 and `frameDone` is 0. A reset in the middle of a frame abandons the frame at once.
- R2: The data register takes `dataIn` on every clock edge where `hostReady` is 1. A change of `dataIn` while `hostReady` is 0 does not alter any later frame.
- R3: On a baud tick in idle, the frame register is loaded as bit 0 = 0 (start), bits 1..8 = data bits 0..7, bit 9 = 1 (stop), and the controller moves to waiting. A data-register write made after that load does not change the frame being sent.
- R4: In waiting, the controller stays put until a baud tick sees `startReq` high. On that clock edge `busy` rises.
- R5: In sending, each baud tick drives frame bit 0 onto `serOut`, shifts the frame one place toward bit 0 and fills a 1 into bit 9. The byte 0x75 therefore appears on the line as 0,1,0,1,0,1,1,1,0,1.
- R6: On the baud tick after the tenth bit has been driven, `frameDone` is 1 for exactly one clock, `busy` falls on that same edge and the controller returns to idle. Exactly ten bits are sent per frame.
- R7: `serOut` is 1 whenever `busy` is 0, including in idle and in waiting.
- R8: `startReq` seen while `busy` is 1 has no effect: the frame and its length are unchanged.
- R9: On clocks without `baudTick`, `serOut` and `busy` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | Single-cycle enable, one per bit period |
| hostReady | input | 1 | Write qualifier for the data register |
| dataIn | input | 8 | Byte from the host |
| startReq | input | 1 | Start request, sampled on baud ticks in waiting |
| serOut | output | 1 | Serial line, idles high |
| busy | output | 1 | High while a frame is on the line |
| frameDone | output | 1 | One-clock strobe at end of frame |

## Verification
A frame register that was loaded wrongly or shifted wrongly shows up on `serOut` in the first baud period whose bit differs. A bit counter that is off by one makes the stop bit too short or adds an extra bit, and this is visible on the tick where `busy` should fall. A controller left in the wrong state shows up as `busy` rising without a start request, or as `frameDone` missing within eleven ticks. The bench compares every port against a behavioural model on every clock, so any such fault is seen within one baud period of the point where it first changes a port.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } txState_e;

  // Strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic loadFrame;
    logic shiftOut;
    logic clearCount;
  } txStrobe_t;

endpackage

// File: rtl/sertx_ctrl.sv
`timescale 1ns/1ps
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int FRAME_LEN = 10,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             startReq,
  input  logic [CNT_W-1:0] bitCnt,
  output txStrobe_t        strobes,
  output txState_e         state,
  output logic             busy,
  output logic             frameDone
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN);

  txState_e nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (baudTick) begin
          strobes.loadFrame = 1'b1;
          nextState         = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (baudTick && startReq) nextState = ST_SEND;
      end
      ST_SEND: begin
        if (baudTick) begin
          if (bitCnt == LAST_CNT) begin
            strobes.clearCount = 1'b1;
            nextState          = ST_IDLE;
          end else begin
            strobes.shiftOut = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      state     <= nextState;
      busy      <= (nextState == ST_SEND);
      frameDone <= strobes.clearCount;
    end
  end

endmodule

// File: rtl/sertx_datapath.sv
`timescale 1ns/1ps
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReady,
  input  logic [WORD_W-1:0] dataIn,
  input  txStrobe_t         strobes,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              serOut
);

  localparam int FRAME_LEN = WORD_W + 2;

  logic [WORD_W-1:0]    dataReg;
  logic [FRAME_LEN-1:0] frameReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataReg <= '0;
    else if (hostReady) dataReg <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '1;
      bitCnt   <= '0;
      serOut   <= 1'b1;
    end else begin
      if (strobes.loadFrame) begin
        frameReg <= {1'b1, dataReg, 1'b0};
      end
      if (strobes.shiftOut) begin
        serOut   <= frameReg[0];
        frameReg <= {1'b1, frameReg[FRAME_LEN-1:1]};
        bitCnt   <= bitCnt + 1'b1;
      end
      if (strobes.clearCount) begin
        bitCnt <= '0;
        serOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
module sertx_top
  import sertx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              hostReady,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              startReq,
  output logic              serOut,
  output logic              busy,
  output logic              frameDone
);

  localparam int FRAME_LEN = WORD_W + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  txStrobe_t        strobes;
  txState_e         state;
  logic [CNT_W-1:0] bitCnt;

  sertx_ctrl #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .startReq(startReq),
    .bitCnt(bitCnt), .strobes(strobes), .state(state),
    .busy(busy), .frameDone(frameDone)
  );

  sertx_datapath #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .hostReady(hostReady), .dataIn(dataIn),
    .strobes(strobes), .bitCnt(bitCnt), .serOut(serOut)
  );

endmodule

// File: rtl/sertx_checker.sv
`timescale 1ns/1ps
module sertx_checker
  import sertx_pkg::*;
#(
  parameter int FRAME_LEN = 10,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             baudTick,
  input logic             startReq,
  input logic             serOut,
  input logic             busy,
  input logic             frameDone,
  input logic [CNT_W-1:0] bitCnt,
  input txState_e         state
);

  a_r7_line_high_when_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> serOut);

  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> ($stable(serOut) && $stable(busy)));

  a_r4_busy_rises_on_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(baudTick) && $past(startReq) && $past(state) == ST_WAIT));

  a_r6_done_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  a_r6_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> frameDone);

  a_r6_done_back_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (state == ST_IDLE && !busy));

  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_LEN));

  a_r8_start_ignored_in_send: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && baudTick && bitCnt != CNT_W'(FRAME_LEN)) |=> busy);

  a_r3_wait_is_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (!busy && serOut && bitCnt == '0));

endmodule

bind sertx_top sertx_checker #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .startReq(startReq),
  .serOut(serOut), .busy(busy), .frameDone(frameDone),
  .bitCnt(bitCnt), .state(state)
);

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
module sertx_top_test;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       hostReady = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       startReq = 1'b0;
  wire        serOut, busy, frameDone;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit tickEn = 1'b0;
  int tickCnt = 0;

  always #2.5 clk = ~clk;

  sertx_top uut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .hostReady(hostReady),
    .dataIn(dataIn), .startReq(startReq), .serOut(serOut), .busy(busy),
    .frameDone(frameDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // baud tick generator
  always @(negedge clk) begin
    if (tickEn) begin
      if (tickCnt == DIV - 1) begin baudTick = 1'b1; tickCnt = 0; end
      else begin baudTick = 1'b0; tickCnt++; end
    end else begin
      baudTick = 1'b0; tickCnt = 0;
    end
  end

  // behavioural reference model
  int         mPhase;
  bit         mSer, mBusy, mDone, shiftedNow;
  logic [7:0] mData;
  bit         mQ[$];
  bit         capBits[$];

  task automatic modelReset();
    mPhase = 0; mSer = 1'b1; mBusy = 1'b0; mDone = 1'b0;
    mData = 8'h00; mQ.delete(); shiftedNow = 1'b0;
  endtask

  always @(posedge clk) begin
    shiftedNow = 1'b0;
    if (!rstN) modelReset();
    else begin
      mDone = 1'b0;
      if (baudTick) begin
        case (mPhase)
          0: begin
            mQ.delete();
            mQ.push_back(1'b0);
            for (int i = 0; i < 8; i++) mQ.push_back(mData[i]);
            mQ.push_back(1'b1);
            mPhase = 1;
          end
          1: if (startReq) begin mPhase = 2; mBusy = 1'b1; end
          default: begin
            if (mQ.size() > 0) begin
              mSer = mQ.pop_front();
              shiftedNow = 1'b1;
            end else begin
              mSer = 1'b1; mBusy = 1'b0; mDone = 1'b1; mPhase = 0;
            end
          end
        endcase
      end
      if (hostReady) mData = dataIn;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(serOut == mSer, "R5/R7 serial line", serOut, mSer);
      check(busy == mBusy, "R4/R6 busy", busy, mBusy);
      check(frameDone == mDone, "R6 frameDone", frameDone, mDone);
      if (shiftedNow) capBits.push_back(serOut);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic writeData(input logic [7:0] v);
    dataIn = v; hostReady = 1'b1;
    @(negedge clk);
    hostReady = 1'b0;
  endtask

  task automatic runFrame(input logic [7:0] expByte, input bit pokeStart,
                          input bit writeDuring, input logic [7:0] newData);
    logic [9:0] expFrame;
    expFrame = {1'b1, expByte, 1'b0};
    capBits.delete();
    startReq = 1'b1;
    while (!busy) @(negedge clk);
    startReq = 1'b0;
    if (writeDuring) writeData(newData);
    if (pokeStart) begin
      repeat (3 * DIV) @(negedge clk);
      startReq = 1'b1;
      repeat (DIV) @(negedge clk);
      startReq = 1'b0;
    end
    while (!frameDone) @(negedge clk);
    check(capBits.size() == 10, "R6 bits per frame", capBits.size(), 10);
    for (int i = 0; i < 10; i++) begin
      if (i < capBits.size())
        check(capBits[i] == expFrame[i], "R3/R5 frame bit", capBits[i], expFrame[i]);
    end
    @(negedge clk);
    check(frameDone == 1'b0, "R6 done is one cycle", frameDone, 0);
  endtask

  initial begin
    logic held;
    modelReset();
    repeat (3) @(negedge clk);
    check(serOut == 1'b1, "R1 reset serOut", serOut, 1);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(frameDone == 1'b0, "R1 reset frameDone", frameDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(serOut == 1'b1 && busy == 1'b0, "R1 after release", {serOut, busy}, 2);

    // R2: 0x75 written, 0xA3 presented without qualifier
    writeData(8'h75);
    dataIn = 8'hA3;
    repeat (2) @(negedge clk);
    tickEn = 1'b1;

    // R3, R5, R8: literal 0x75 frame, write during send, start poked while busy
    runFrame(8'h75, 1'b1, 1'b1, 8'hC4);
    check(capBits.size() == 10 && {capBits[9], capBits[8], capBits[7], capBits[6],
          capBits[5], capBits[4], capBits[3], capBits[2], capBits[1], capBits[0]}
          == 10'b1011101010, "R5 literal 0x75 waveform", capBits.size(), 10);

    // new data picked up on next idle tick
    runFrame(8'hC4, 1'b0, 1'b0, 8'h00);

    // R2: dataIn changes without hostReady are ignored
    dataIn = 8'h5A;
    runFrame(8'hC4, 1'b0, 1'b0, 8'h00);

    // R4, R7: parked in waiting without start
    writeData(8'hFF);
    repeat (8 * DIV) begin
      @(negedge clk);
      check(serOut == 1'b1 && busy == 1'b0, "R4/R7 waiting idle line", {serOut, busy}, 2);
    end
    runFrame(8'hFF, 1'b0, 1'b1, 8'h00);
    runFrame(8'h00, 1'b1, 1'b1, 8'h81);

    // R9: ticks stopped mid-frame freeze the line
    startReq = 1'b1;
    while (!busy) @(negedge clk);
    startReq = 1'b0;
    repeat (3 * DIV + 1) @(negedge clk);
    tickEn = 1'b0;
    @(negedge clk);
    held = serOut;
    repeat (20) begin
      @(negedge clk);
      check(serOut == held && busy == 1'b1, "R9 hold without tick", serOut, held);
    end
    tickEn = 1'b1;
    while (!frameDone) @(negedge clk);

    // R1: reset in the middle of a frame
    writeData(8'h00);
    startReq = 1'b1;
    while (!busy) @(negedge clk);
    startReq = 1'b0;
    repeat (2 * DIV + 2) @(negedge clk);
    rstN = 1'b0;
    modelReset();
    #1;
    check(serOut == 1'b1, "R1 mid-frame reset serOut", serOut, 1);
    check(busy == 1'b0, "R1 mid-frame reset busy", busy, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && frameDone == 1'b0, "R1 idle after reset", {busy, frameDone}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule